// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a reference clock under control of a nine-bit clock-control word. The low eight bits pick the divide ratio with a one-hot selector: the highest set bit decides it, and each step one bit lower doubles the card clock frequency. Bit 8 is the card clock enable. A separate bypass input gives the fastest rate, but only while the selector is all zeros. The reference clock `clk` runs at twice the host clock rate. As a result, every card clock rate, including the bypass rate equal to the host clock, is produced by a flip-flop bit and never by gating a clock.

The core is a three-state machine: `SC_IDLE` (clock stopped, parked low), `SC_HIGH` (high phase) and `SC_LOW` (low phase). A phase counter times each phase to the active half-period. The transitions are:

- `SC_IDLE -> SC_HIGH` when the enable is set.
- `SC_HIGH -> SC_LOW` at the end of the high phase.
- `SC_LOW -> SC_HIGH` at the end of the low phase when the enable is still set. The requested ratio is latched at this point.
- `SC_LOW -> SC_IDLE` at the end of the low phase when the enable is clear.

Every other case holds the current state. A combinational `ready` output tells software when the running clock matches the request, so it can wait before using the card.

Top module: `sdclk_divider`

## Requirements
- R1: After reset, `card_clk` is low and `ready` is high while the enable bit (bit 8) is clear.
- R2: With enable set and highest selector bit k (bits 7..0), each high phase and each low phase of `card_clk` lasts 2^(k+2) `clk` cycles. Bit 7 therefore gives 512 cycles per phase, which is the host clock divided by 512.
- R3: With enable set, selector zero and bypass low, each phase lasts 2 `clk` cycles, which is the host clock divided by 2.
- R4: With enable set, selector zero and bypass high, each phase lasts 1 `clk` cycle, which is the full host clock. Bypass has no effect while any selector bit is set.
- R5: When several selector bits are set, only the highest one sets the ratio.
- R6: Clearing the enable lets the current high phase and the following low phase finish at full length. After that `card_clk` parks low and stays low.
- R7: From the stopped state, `card_clk` is high one `clk` cycle after the enable is sampled. A ratio change made during a high phase takes effect only after that high phase and its low phase finish at the old length.
- R8: Every completed high phase has a power-of-two length of at most 512 cycles. The low phase that follows it is at least as long, so no runt pulse is produced.
- R9: `ready` is high exactly when the clock is stopped with enable clear, or running at the requested ratio with enable set. It drops in the same cycle the request changes.
- R10: Clearing and then setting the enable again, with the selector unchanged, resumes at the same ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the host clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctl | input | 9 | Bit 8 is the enable; bits 7..0 are the one-hot ratio selector |
| bypass | input | 1 | Selects the full host clock when the selector is zero |
| card_clk | output | 1 | Card clock, driven straight from a state flip-flop |
| ready | output | 1 | Running clock matches the request |

## Verification
The in-design assertions check several things on every cycle:
- `card_clk` changes only at the end of a counted phase or when leaving the stopped state.
- The phase counter never passes the active half-period.
- The latched ratio is stable across a high phase.
- `ready` together with a set enable implies a running clock.
- A stopped, ready clock is low.

The phase lengths for each selector and bypass pattern, the handling of a mid-phase ratio change or disable, the one-cycle start latency, and the absence of runt phases over the whole run can only be shown by the bench's scenarios and its phase-length monitor.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    // Bit 0 of the state encoding is the card clock level itself.
    typedef enum logic [1:0] {
        SC_IDLE = 2'b00,
        SC_HIGH = 2'b01,
        SC_LOW  = 2'b10
    } sc_state_e;
endpackage

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel #(
    parameter int SEL_W = 8,
    parameter int EXP_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             bypass,
    output logic [EXP_W-1:0] half_exp
);
    // Half-period is 2**half_exp reference cycles; the highest set bit wins.
    always_comb begin
        half_exp = bypass ? '0 : EXP_W'(1);
        for (int i = 0; i < SEL_W; i++) begin
            if (sel[i]) half_exp = EXP_W'(i + 2);
        end
    end
endmodule

// File: rtl/sdclk_phase_fsm.sv
module sdclk_phase_fsm
    import sdclk_pkg::*;
#(
    parameter int EXP_W = 4,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_en,
    input  logic [EXP_W-1:0] req_exp,
    output logic             card_clk,
    output logic             ready
);
    sc_state_e        state, state_nx;
    logic [EXP_W-1:0] act_exp, act_exp_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W:0]   half_full;
    logic [CNT_W-1:0] half_m1;
    logic             phase_end;

    always_comb begin
        half_full = (CNT_W+1)'(1) << act_exp;
        half_m1   = half_full[CNT_W-1:0] - 1'b1;
        phase_end = (cnt == half_m1);
    end

    always_comb begin
        state_nx   = state;
        act_exp_nx = act_exp;
        cnt_nx     = cnt + 1'b1;
        unique case (state)
            SC_IDLE: begin
                cnt_nx = '0;
                if (req_en) begin
                    state_nx   = SC_HIGH;
                    act_exp_nx = req_exp;
                end
            end
            SC_HIGH: begin
                if (phase_end) begin
                    state_nx = SC_LOW;
                    cnt_nx   = '0;
                end
            end
            SC_LOW: begin
                if (phase_end) begin
                    cnt_nx = '0;
                    if (req_en) begin
                        state_nx   = SC_HIGH;
                        act_exp_nx = req_exp;
                    end else begin
                        state_nx = SC_IDLE;
                    end
                end
            end
            default: state_nx = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SC_IDLE;
            act_exp <= '0;
            cnt     <= '0;
        end else begin
            state   <= state_nx;
            act_exp <= act_exp_nx;
            cnt     <= cnt_nx;
        end
    end

    always_comb begin
        card_clk = state[0];
        if (state == SC_IDLE) ready = !req_en;
        else                  ready = req_en && (act_exp == req_exp);
    end

    // R8
    edge_at_phase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(card_clk) || $fell(card_clk)) |-> ($past(phase_end) || $past(state == SC_IDLE)));
    // R8
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= half_m1);
    // R7
    ratio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_HIGH) |=> $stable(act_exp));
    // R9
    ready_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_en) |-> (state != SC_IDLE));
    // R6
    park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !req_en) |-> !card_clk);
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
    parameter int SEL_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SEL_W:0] clk_ctl,
    input  logic           bypass,
    output logic           card_clk,
    output logic           ready
);
    localparam int EXP_W = $clog2(SEL_W + 2);
    localparam int CNT_W = SEL_W + 1;

    logic [EXP_W-1:0] req_exp;

    sdclk_ratio_sel #(.SEL_W(SEL_W), .EXP_W(EXP_W)) u_sel (
        .sel      (clk_ctl[SEL_W-1:0]),
        .bypass   (bypass),
        .half_exp (req_exp)
    );

    sdclk_phase_fsm #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_en   (clk_ctl[SEL_W]),
        .req_exp  (req_exp),
        .card_clk (card_clk),
        .ready    (ready)
    );
endmodule

// File: tb/sim_sdclk_divider.sv
`timescale 1ns/1ps
module sim_sdclk_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] clk_ctl = '0;
    logic       bypass = 1'b0;
    logic       card_clk, ready;

    int n_chk = 0;
    int n_err = 0;
    int mon_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sdclk_divider u0 (.clk(clk), .rst_n(rst_n), .clk_ctl(clk_ctl),
                      .bypass(bypass), .card_clk(card_clk), .ready(ready));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_half(input logic [7:0] sel, input logic byp);
        if (sel == 0) return byp ? 1 : 2;
        for (int i = 7; i >= 0; i--) if (sel[i]) return 1 << (i + 2);
        return 0;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 3000 && !ready; i++) step();
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        for (int i = 0; i < 2000 && card_clk; i++) step();
        for (int i = 0; i < 2000 && !card_clk; i++) step();
        while (card_clk && hi < 2000) begin hi++; step(); end
        while (!card_clk && lo < 2000) begin lo++; step(); end
    endtask

    // R8: phase-length monitor over the whole run
    int run_len = 0, last_hi = 0;
    logic prev_clk = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (card_clk != prev_clk) begin
                if (prev_clk) begin
                    if ((run_len & (run_len - 1)) != 0 || run_len > 512) mon_err++;
                    last_hi = run_len;
                end else if (last_hi > 0 && run_len < last_hi) begin
                    mon_err++;
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            prev_clk = card_clk;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int hi, lo, h2, l2, e;
        int unsigned seed;
        logic [7:0] s;
        logic b;
        seed = $urandom(32'd4242);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(card_clk == 1'b0, "R1 clk", card_clk, 0);
        check(ready == 1'b1, "R1 ready", ready, 1);

        // R7: start latency
        clk_ctl = 9'h101; #1;
        check(ready == 1'b0, "R9 drop", ready, 0);
        step();
        check(card_clk == 1'b1, "R7 start", card_clk, 1);
        wait_ready(); measure(hi, lo);
        check(hi == 4 && lo == 4, "R2 bit0", hi, 4);

        clk_ctl = 9'h100; bypass = 0; wait_ready(); measure(hi, lo);
        check(hi == 2 && lo == 2, "R3 div2", hi, 2);
        bypass = 1; wait_ready(); measure(hi, lo);
        check(hi == 1 && lo == 1, "R4 bypass", hi, 1);
        clk_ctl = 9'h104; wait_ready(); measure(hi, lo);
        check(hi == 16 && lo == 16, "R4 bypass ignored", hi, 16);
        bypass = 0;
        clk_ctl = 9'h180; wait_ready(); measure(hi, lo);
        check(hi == 512 && lo == 512, "R2 slowest", hi, 512);
        clk_ctl = 9'h125; wait_ready(); measure(hi, lo);
        check(hi == 128 && lo == 128, "R5 highest wins", hi, 128);

        // R10: restart keeps ratio
        clk_ctl = 9'h110; wait_ready(); measure(hi, lo);
        clk_ctl = 9'h010; wait_ready();
        clk_ctl = 9'h110; wait_ready(); measure(h2, l2);
        check(hi == 64 && h2 == 64 && l2 == 64, "R10 restart", h2, 64);

        // R6: disable during high phase
        clk_ctl = 9'h108; wait_ready();
        for (int i = 0; i < 2000 && card_clk; i++) step();
        for (int i = 0; i < 2000 && !card_clk; i++) step();
        hi = 1;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (hi == 3) clk_ctl = 9'h008;
            if (card_clk) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (!ready && !card_clk) lo++; else break;
        end
        check(hi == 32, "R6 high completes", hi, 32);
        check(lo == 32, "R6 low completes", lo, 32);
        e = 0;
        repeat (300) begin step(); if (card_clk) e++; end
        check(e == 0, "R6 parked low", e, 0);

        // R7: ratio change during high phase
        clk_ctl = 9'h102; wait_ready();
        for (int i = 0; i < 2000 && card_clk; i++) step();
        for (int i = 0; i < 2000 && !card_clk; i++) step();
        hi = 1; step(); hi++;
        clk_ctl = 9'h108; #1;
        check(ready == 1'b0, "R9 drop on change", ready, 0);
        for (int i = 0; i < 2000; i++) begin step(); if (card_clk) hi++; else break; end
        lo = 1;
        for (int i = 0; i < 2000; i++) begin step(); if (!card_clk) lo++; else break; end
        h2 = 1;
        for (int i = 0; i < 2000; i++) begin step(); if (card_clk) h2++; else break; end
        check(hi == 8, "R7 old high", hi, 8);
        check(lo == 8, "R7 old low", lo, 8);
        check(h2 == 32, "R7 new high", h2, 32);

        // Random patterns, R2 R3 R4 R5
        for (int k = 0; k < 16; k++) begin
            case ($urandom % 4)
                0: s = 8'h00;
                1: s = 8'h01 << ($urandom % 8);
                default: s = 8'($urandom);
            endcase
            b = 1'($urandom);
            clk_ctl = {1'b1, s}; bypass = b;
            wait_ready();
            check(ready == 1'b1, "R9 ready", ready, 1);
            measure(hi, lo);
            check(hi == exp_half(s, b) && lo == exp_half(s, b), "R2 random", hi, exp_half(s, b));
        end

        check(mon_err == 0, "R8 no runt", mon_err, 0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule